// File: doc/BRIEF.md
# Tiled Matrix Multiply-Accumulate Unit

This unit sits beside a processor core and multiplies square blocks of signed 8-bit data. The core drives it with three custom commands, all carrying the major opcode 0x7b in the I-type layout. A fill command copies operand bytes from a byte-wide memory port into an internal operand store. A product command accumulates block products into a T×T array of 32-bit accumulators that stays in place between commands. A drain command writes the accumulators back to memory and then wipes all internal storage.

Before any fill or product, a control register at address 0xFC4 must be set to the number of T×T blocks along the shared (reduction) dimension. Call this value n. It fixes two things: where operand B sits in the operand store, and the fixed run time of a product. While a command runs, the unit holds `busy` high. It raises `done` for exactly one cycle as the command finishes. An unknown command raises `err` for one cycle and changes nothing.

Top module: `tile_mma_unit`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_req` are low and the block-count register reads 0. A drain issued right after reset writes only zero bytes.
- R2: The block-count register sits at CSR address 0xFC4 and reads back zero-extended. A written value above MAX_TILES is stored as MAX_TILES. Any other address reads 0. A write while `busy` is high is dropped.
- R3: A command is taken only when `cmd_valid` is high, `busy` is low and `cmd_opcode` equals 7'h7b. A command with any other opcode leaves `busy` low and issues no memory request.
- R4: funct3 selects the command: 0 is fill, 1 is drain, 2 is product. funct3 values 3 to 7, or a fill with an immediate above 1, are illegal. An illegal command sets `err` high for exactly the cycle after acceptance, keeps `busy` low and leaves the operand store and accumulators unchanged.
- R5: A fill issues n·T·T byte reads at `cmd_addr`+i, in order. Read data is taken from `mem_rdata` in the cycle after each request. Byte i goes to store index i when the immediate is 0 (operand A) and to index n·T·T+i when it is 1 (operand B). `done` rises two cycles after the last request (n>0), or one cycle after acceptance when n=0.
- R6: A product adds, for every block k<n, A_k×B_k into the accumulators, using two's-complement 32-bit arithmetic. Element (r,c) of A_k is store index k·T·T+r·T+c. Element (r,c) of B_k is store index n·T·T+k·T·T+r·T+c.
- R7: The `done` of a product is high in the cycle that starts exactly n·T+2·T rising edges after the accepting edge.
- R8: A drain issues T·T·4 byte writes at `cmd_addr`+i. Each accumulator is written in row-major order, least significant byte first. `done` is high in the cycle of the last write.
- R9: After a drain, every operand and accumulator entry is zero. A second drain writes only zeros.
- R10: Accumulators keep their values across products. Two products on the same operands give twice the single result.
- R11: `done` lasts one cycle, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_opcode | input | 7 | Major opcode of the command |
| cmd_funct3 | input | 3 | Command selector |
| cmd_imm | input | 12 | Immediate; operand select for a fill |
| cmd_addr | input | 32 | Base byte address from the source register |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 12 | Control register address |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read data (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-command pulse |

## Verification
A wrong operand index, a missed sign extension or a stray accumulation step shows up as wrong bytes at the drain. A drain of T·T·4 bytes follows each product, so such a fault appears within about 70 cycles of the product finishing. A miscounted latency counter moves the `done` pulse away from cycle n·T+2·T and is seen on the first product. A failed clear or a corrupting illegal command shows up as nonzero bytes or a changed product on the very next drain.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    localparam logic [6:0]  OPC_TILE  = 7'h7b;
    localparam logic [11:0] CSR_TILES = 12'hFC4;

    typedef enum logic [1:0] {
        CMD_FILL  = 2'd0,
        CMD_DRAIN = 2'd1,
        CMD_MUL   = 2'd2,
        CMD_BAD   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_MUL   = 2'd2,
        ST_DRAIN = 2'd3
    } st_e;
endpackage

// File: rtl/tmu_decode.sv
module tmu_decode
    import tmu_pkg::*;
(
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [11:0] imm,
    output logic        hit,
    output cmd_e        kind,
    output logic        illegal
);
    always_comb begin
        hit = (opcode == OPC_TILE);
        case (funct3)
            3'd0:    kind = CMD_FILL;
            3'd1:    kind = CMD_DRAIN;
            3'd2:    kind = CMD_MUL;
            default: kind = CMD_BAD;
        endcase
        illegal = (kind == CMD_BAD) || ((kind == CMD_FILL) && (imm > 12'd1));
    end
endmodule

// File: rtl/tmu_scratch.sv
module tmu_scratch #(
    parameter int ENT = 64,
    localparam int AW = $clog2(ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [7:0]        wdata,
    output logic [ENT*8-1:0]  data
);
    logic [ENT*8-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            mem_d = '0;
        end else if (we) begin
            mem_d[int'(waddr)*8 +: 8] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign data = mem_q;

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (data[int'($past(waddr))*8 +: 8] == $past(wdata)));

    // R9
    store_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (data == '0));
endmodule

// File: rtl/tmu_mac_array.sv
module tmu_mac_array #(
    parameter int T         = 4,
    parameter int MAX_TILES = 2,
    parameter int ACC_W     = 32,
    localparam int TT   = T * T,
    localparam int SP_N = 2 * MAX_TILES * TT,
    localparam int TW   = $clog2(MAX_TILES + 1),
    localparam int KW   = $clog2(T + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step_en,
    input  logic [TW-1:0]        step_tile,
    input  logic [KW-1:0]        step_kk,
    input  logic [TW-1:0]        ntile,
    input  logic [SP_N*8-1:0]    opnd,
    output logic [TT*ACC_W-1:0]  acc
);
    logic signed [ACC_W-1:0] prod [TT];
    logic [TT*ACC_W-1:0] acc_d, acc_q;

    for (genvar gr = 0; gr < T; gr++) begin : g_row
        for (genvar gc = 0; gc < T; gc++) begin : g_col
            int ai, bi;
            logic signed [7:0]  av, bv;
            logic signed [15:0] p;
            always_comb begin
                ai = int'(step_tile) * TT + gr * T + int'(step_kk);
                bi = int'(ntile) * TT + int'(step_tile) * TT + int'(step_kk) * T + gc;
                if (ai >= SP_N) ai = 0;
                if (bi >= SP_N) bi = 0;
                av = opnd[ai*8 +: 8];
                bv = opnd[bi*8 +: 8];
                p  = av * bv;
            end
            assign prod[gr*T+gc] = {{(ACC_W-16){p[15]}}, p};
        end
    end

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (step_en) begin
            for (int c = 0; c < TT; c++) begin
                acc_d[c*ACC_W +: ACC_W] = acc_q[c*ACC_W +: ACC_W] + prod[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step_en) |=> $stable(acc));

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/tile_mma_unit.sv
module tile_mma_unit
    import tmu_pkg::*;
#(
    parameter int T         = 4,
    parameter int MAX_TILES = 2,
    parameter int ACC_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [6:0]  cmd_opcode,
    input  logic [2:0]  cmd_funct3,
    input  logic [11:0] cmd_imm,
    input  logic [31:0] cmd_addr,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int TT      = T * T;
    localparam int SP_N    = 2 * MAX_TILES * TT;
    localparam int SAW     = $clog2(SP_N);
    localparam int DRN_N   = TT * (ACC_W / 8);
    localparam int FILL_MX = MAX_TILES * TT;
    localparam int LAT_MX  = MAX_TILES * T + 2 * T;
    localparam int CMAX_A  = (DRN_N > FILL_MX) ? DRN_N : FILL_MX;
    localparam int CMAX    = (CMAX_A > LAT_MX) ? CMAX_A : LAT_MX;
    localparam int CW      = $clog2(CMAX + 1);
    localparam int TW      = $clog2(MAX_TILES + 1);
    localparam int KW      = $clog2(T + 1);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [31:0]   base;
        logic          opb;
        logic          pend;
        logic [CW-1:0] pidx;
        logic [TW-1:0] tile;
        logic [KW-1:0] kk;
        logic [TW-1:0] ntile;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic          dec_hit, dec_illegal;
    cmd_e          dec_kind;
    logic          sp_we, clr_all, step_en;
    logic [SAW-1:0] sp_waddr;
    logic [SP_N*8-1:0]  opnd;
    logic [TT*ACC_W-1:0] acc;

    tmu_decode u_dec (
        .opcode  (cmd_opcode),
        .funct3  (cmd_funct3),
        .imm     (cmd_imm),
        .hit     (dec_hit),
        .kind    (dec_kind),
        .illegal (dec_illegal)
    );

    tmu_scratch #(.ENT(SP_N)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .we    (sp_we),
        .waddr (sp_waddr),
        .wdata (mem_rdata),
        .data  (opnd)
    );

    tmu_mac_array #(.T(T), .MAX_TILES(MAX_TILES), .ACC_W(ACC_W)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_all),
        .step_en   (step_en),
        .step_tile (r_q.tile),
        .step_kk   (r_q.kk),
        .ntile     (r_q.ntile),
        .opnd      (opnd),
        .acc       (acc)
    );

    always_comb begin
        int n_el;
        int lat;
        r_d       = r_q;
        r_d.err   = 1'b0;
        n_el      = int'(r_q.ntile) * TT;
        lat       = int'(r_q.ntile) * T + 2 * T;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.base + 32'(r_q.cnt);
        mem_wdata = '0;
        sp_we     = 1'b0;
        sp_waddr  = SAW'((r_q.opb ? n_el : 0) + int'(r_q.pidx));
        step_en   = 1'b0;
        done      = 1'b0;
        clr_all   = 1'b0;
        csr_rdata = (csr_addr == CSR_TILES) ? 32'(r_q.ntile) : 32'd0;

        case (r_q.st)
            ST_IDLE: begin
                if (csr_we && (csr_addr == CSR_TILES)) begin
                    r_d.ntile = (csr_wdata > 32'(MAX_TILES)) ? TW'(MAX_TILES)
                                                             : csr_wdata[TW-1:0];
                end
                if (cmd_valid && dec_hit) begin
                    if (dec_illegal) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.base = cmd_addr;
                        r_d.opb  = cmd_imm[0];
                        r_d.pend = 1'b0;
                        r_d.tile = '0;
                        r_d.kk   = '0;
                        r_d.cnt  = (dec_kind == CMD_MUL) ? CW'(1) : '0;
                        case (dec_kind)
                            CMD_FILL:  r_d.st = ST_FILL;
                            CMD_DRAIN: r_d.st = ST_DRAIN;
                            default:   r_d.st = ST_MUL;
                        endcase
                    end
                end
            end
            ST_FILL: begin
                sp_we = r_q.pend;
                if (int'(r_q.cnt) < n_el) begin
                    mem_req  = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.pend = 1'b1;
                    r_d.pidx = r_q.cnt;
                end else begin
                    r_d.pend = 1'b0;
                    if (!r_q.pend) begin
                        done     = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            ST_MUL: begin
                if (int'(r_q.cnt) <= int'(r_q.ntile) * T) begin
                    step_en = 1'b1;
                    if (r_q.kk == KW'(T - 1)) begin
                        r_d.kk   = '0;
                        r_d.tile = r_q.tile + 1'b1;
                    end else begin
                        r_d.kk = r_q.kk + 1'b1;
                    end
                end
                if (int'(r_q.cnt) == lat) begin
                    done   = 1'b1;
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = acc[int'(r_q.cnt)*8 +: 8];
                if (int'(r_q.cnt) == DRN_N - 1) begin
                    done    = 1'b1;
                    clr_all = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign err  = r_q.err;

    // R11
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R4
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R3
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8
    write_only_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && (r_q.st == ST_DRAIN)));

    // R2
    tiles_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && csr_we) |=> $stable(csr_rdata) || (csr_addr != $past(csr_addr)));

    // R2
    tiles_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ntile <= TW'(MAX_TILES)));
endmodule

// File: tb/tb_tile_mma_unit.sv
`timescale 1ns/1ps
module tb_tile_mma_unit;
    localparam int T  = 4;
    localparam int MT = 2;
    localparam int TT = T * T;
    localparam int A_BASE = 0;
    localparam int B_BASE = 64;
    localparam int C_BASE = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [6:0]  cmd_opcode = 7'h7b;
    logic [2:0]  cmd_funct3 = '0;
    logic [11:0] cmd_imm = '0;
    logic [31:0] cmd_addr = '0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = 12'hFC4;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, err;

    logic [7:0] mem [512];
    int n_chk = 0;
    int n_err = 0;
    int req_cnt = 0;
    int wr_cnt = 0;

    always #2.5 clk = ~clk;

    tile_mma_unit #(.T(T), .MAX_TILES(MT), .ACC_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_funct3(cmd_funct3), .cmd_imm(cmd_imm), .cmd_addr(cmd_addr),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                mem[mem_addr[8:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[8:0]];
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [6:0] opc, input logic [2:0] f3,
                         input logic [11:0] imm, input int addr, output int lat);
        @(negedge clk);
        cmd_opcode = opc; cmd_funct3 = f3; cmd_imm = imm; cmd_addr = addr;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic set_tiles(input int v);
        @(negedge clk);
        csr_addr = 12'hFC4; csr_wdata = v; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    function automatic int exp_c(input int e, input int n, input int m);
        int s = 0;
        int r = e / T;
        int c = e % T;
        for (int k = 0; k < n; k++)
            for (int q = 0; q < T; q++)
                s += int'($signed(mem[A_BASE + k*TT + r*T + q])) *
                     int'($signed(mem[B_BASE + k*TT + q*T + c]));
        return s * m;
    endfunction

    function automatic logic [31:0] got_c(input int e);
        return {mem[C_BASE+e*4+3], mem[C_BASE+e*4+2], mem[C_BASE+e*4+1], mem[C_BASE+e*4]};
    endfunction

    task automatic prep_out();
        for (int i = 0; i < 64; i++) mem[C_BASE + i] = 8'hA5;
    endtask

    task automatic fill_both(input int n, input string rq);
        int lat;
        issue(7'h7b, 3'd0, 12'd0, A_BASE, lat);
        chk(rq, lat, (n == 0) ? 1 : n*TT + 2);
        issue(7'h7b, 3'd0, 12'd1, B_BASE, lat);
        chk(rq, lat, (n == 0) ? 1 : n*TT + 2);
    endtask

    task automatic drain_check(input int n, input int m, input string rq);
        int lat;
        int w0;
        prep_out();
        w0 = wr_cnt;
        issue(7'h7b, 3'd1, 12'd0, C_BASE, lat);
        chk({rq, " drain latency (R8)"}, lat, 64);
        @(negedge clk);
        chk({rq, " write count (R8)"}, wr_cnt - w0, 64);
        for (int e = 0; e < TT; e++) chk(rq, got_c(e), exp_c(e, n, m));
    endtask

    initial begin
        int lat;
        int r0;
        for (int i = 0; i < 512; i++) mem[i] = (i < 128) ? 8'((i*73 + 19) ^ (i >> 2)) : 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 mem_req", mem_req, 0);
        #1 chk("R1 tile count", csr_rdata, 0);
        rst_n = 1'b1;
        drain_check(0, 0, "R1 zero drain");

        // R2 register access
        set_tiles(5);
        #1 chk("R2 saturate", csr_rdata, MT);
        set_tiles(1);
        #1 chk("R2 readback", csr_rdata, 1);
        csr_addr = 12'hFC0;
        #1 chk("R2 other addr", csr_rdata, 0);
        csr_addr = 12'hFC4;

        // R5 R6 R7 R9 single product per block count
        for (int n = 1; n <= MT; n++) begin
            set_tiles(n);
            fill_both(n, "R5 fill latency");
            issue(7'h7b, 3'd2, 12'd0, 0, lat);
            chk("R7 product latency", lat, n*T + 2*T);
            @(negedge clk);
            chk("R11 done ends", done, 0);
            chk("R11 busy falls", busy, 0);
            drain_check(n, 1, "R6 product");
            drain_check(n, 0, "R9 cleared");
        end

        // R10 two products accumulate
        set_tiles(2);
        fill_both(2, "R5 fill latency");
        issue(7'h7b, 3'd2, 12'd0, 0, lat);
        issue(7'h7b, 3'd2, 12'd0, 0, lat);
        drain_check(2, 2, "R10 accumulate");

        // R7 zero block count
        set_tiles(0);
        issue(7'h7b, 3'd2, 12'd0, 0, lat);
        chk("R7 zero-count latency", lat, 2*T);
        drain_check(0, 0, "R7 zero-count result");

        // R4 illegal commands, R3 foreign opcode
        set_tiles(1);
        fill_both(1, "R5 fill latency");
        for (int f = 3; f < 8; f++) begin
            @(negedge clk);
            cmd_opcode = 7'h7b; cmd_funct3 = 3'(f); cmd_imm = '0; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R4 err raised", err, 1);
            chk("R4 not busy", busy, 0);
            @(negedge clk);
            chk("R4 err one cycle", err, 0);
        end
        @(negedge clk);
        cmd_opcode = 7'h7b; cmd_funct3 = 3'd0; cmd_imm = 12'd2; cmd_addr = 100; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R4 bad operand err", err, 1);
        chk("R4 bad operand idle", busy, 0);
        r0 = req_cnt;
        @(negedge clk);
        cmd_opcode = 7'h0b; cmd_funct3 = 3'd2; cmd_imm = '0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 foreign busy", busy, 0);
        chk("R3 foreign err", err, 0);
        repeat (3) @(negedge clk);
        chk("R3 foreign no request", req_cnt - r0, 0);
        issue(7'h7b, 3'd2, 12'd0, 0, lat);
        drain_check(1, 1, "R4 store unchanged");

        // R2 write while busy is dropped
        set_tiles(1);
        fill_both(1, "R5 fill latency");
        @(negedge clk);
        cmd_opcode = 7'h7b; cmd_funct3 = 3'd2; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        csr_wdata = 2; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin @(negedge clk); lat++; end
        @(negedge clk);
        #1 chk("R2 busy write dropped", csr_rdata, 1);
        drain_check(1, 1, "R2 product after dropped write");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule